// File: doc/BRIEF.md
# Random Allocation Tag Generator

This block picks a 4-bit memory allocation tag and writes it into the tag field of a 64-bit pointer. It has two request kinds. A generate request draws a pseudo-random step count from a 16-bit linear feedback seed and walks forward from the last issued tag. Each step lands only on values that are allowed by an exclusion mask. An add-tag request starts from the tag already held in the pointer and walks forward by an offset the caller supplies. In that walk it skips the values the control mask excludes. It also adds a signed byte offset to the pointer.

The caller owns the start/seed state word and presents it with each request. A generate request returns a rewritten state word, and the caller stores it for the next request. The seed can be refilled from an external entropy port. The caller hands over one request per valid/ready handshake. Results appear with a one-cycle done pulse and stay on the outputs until the next request is accepted.

Control flow is a five-state machine:
- `ST_IDLE` accepts a request. A generate request moves to `ST_SEED`, and an add-tag request moves to `ST_WALK`.
- `ST_SEED` refills a zero seed when random refill is enabled, then moves to `ST_SHIFT`.
- `ST_SHIFT` runs four feedback steps, one per cycle, then moves to `ST_WALK`.
- `ST_WALK` advances the tag by one value per cycle until the walk finishes, then moves to `ST_DONE`.
- `ST_DONE` raises done for one cycle and returns to `ST_IDLE`.

Top module: `alloc_tag_gen`

## Requirements
- R1: In generate mode the exclusion set is the bitwise OR of `req_excl` and `ctrl_excl`, where bit n set excludes tag value n. If all 16 bits of the exclusion set are ones, the result tag is 0.
- R2: After a generate request, `res_state` holds the new tag in bits 3:0, zeros in bits 7:4, and the new seed in bits 23:8. After an add-tag request, `res_state` equals the `req_state` that was accepted.
- R3: A generate request advances the seed four times. Each step computes a feedback bit as the XOR of seed bits 0, 2, 3 and 5, shifts the seed right by one, and inserts the feedback bit at bit 15.
- R4: The four feedback bits form the walk offset: the first step gives bit 0 of the offset and the fourth step gives bit 3.
- R5: With a walk offset of 0, the result is the start tag if that tag is allowed. Otherwise the tag increments modulo 16 until it reaches an allowed value.
- R6: With a nonzero walk offset k, the tag increments modulo 16 and counts only the allowed values it lands on. It stops at the k-th allowed value.
- R7: A generate request with `rand_en`=1 and a zero seed first loads the seed from `ent_value`. If `ent_fail`=1 or `ent_value` is 0, the value 1 is loaded instead. With `rand_en`=0, a zero seed is left as it is.
- R8: An add-tag request (`req_op`=1) takes its start tag from pointer bits 59:56 and its walk offset from `req_tag_ofs`. It uses `ctrl_excl` alone and ignores `req_excl`. The result pointer is `req_ptr` plus the two's-complement `req_byte_ofs`, with the new tag written into bits 59:56.
- R9: The tag occupies pointer bits 59:56. In generate mode all other bits of `res_ptr` equal `req_ptr`.
- R10: `req_ready` is high only when the block is idle, and it drops in the cycle after a request is accepted. `done` lasts exactly one cycle. `res_ptr` and `res_state` hold their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_op | input | 1 | 0 = generate, 1 = add-tag |
| req_ptr | input | 64 | Source pointer |
| req_byte_ofs | input | 64 | Signed byte offset (add-tag only) |
| req_excl | input | 16 | Per-request exclusion mask (generate only) |
| req_tag_ofs | input | 4 | Tag walk offset (add-tag only) |
| req_state | input | 24 | Start tag [3:0] and seed [23:8] |
| ctrl_excl | input | 16 | Control exclusion mask |
| rand_en | input | 1 | Allow refill of a zero seed |
| ent_value | input | 16 | Entropy value for refill |
| ent_fail | input | 1 | Entropy value unusable |
| done | output | 1 | One-cycle result pulse |
| res_ptr | output | 64 | Pointer with new tag |
| res_state | output | 24 | Updated state word |

## Verification
The assertions rely on the request fields and `ctrl_excl` being sampled in the accept cycle. They also rely on `ent_value` and `ent_fail` being stable in the cycle after a generate request is accepted. The seed-nonzero property holds only because a refilled seed is never zero and the feedback step maps nonzero seeds to nonzero seeds. The stimulus keeps every input stable from the falling edge before acceptance until done is seen, and it changes inputs only on falling edges. The bench therefore never presents entropy that differs between acceptance and refill.

// File: rtl/atg_pkg.sv
`timescale 1ns/1ps
package atg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEED,
        ST_SHIFT,
        ST_WALK,
        ST_DONE
    } atg_state_e;

    typedef enum logic {
        OP_GEN    = 1'b0,
        OP_ADDSUB = 1'b1
    } atg_op_e;
endpackage

// File: rtl/atg_lfsr_step.sv
`timescale 1ns/1ps
// One right-shift step of the Fibonacci seed register.
module atg_lfsr_step #(
    parameter int              SEED_W = 16,
    parameter logic [SEED_W-1:0] TAPS = 16'h002D
) (
    input  logic [SEED_W-1:0] seed_i,
    output logic [SEED_W-1:0] seed_o,
    output logic              fb_o
);
    always_comb begin
        fb_o   = ^(seed_i & TAPS);
        seed_o = {fb_o, seed_i[SEED_W-1:1]};
    end
endmodule

// File: rtl/atg_skip_step.sv
`timescale 1ns/1ps
// One cycle of the excluded-value walk.
module atg_skip_step #(
    parameter int TAG_W = 4,
    localparam int NTAGS = 1 << TAG_W
) (
    input  logic [TAG_W-1:0] tag_i,
    input  logic [TAG_W-1:0] rem_i,
    input  logic [NTAGS-1:0] excl_i,
    output logic [TAG_W-1:0] tag_o,
    output logic [TAG_W-1:0] rem_o,
    output logic             fin_o
);
    logic [TAG_W-1:0] tag_inc;

    always_comb begin
        tag_inc = tag_i + TAG_W'(1);
        tag_o   = tag_i;
        rem_o   = rem_i;
        fin_o   = 1'b0;
        if (&excl_i) begin
            tag_o = '0;
            rem_o = '0;
            fin_o = 1'b1;
        end else if (rem_i == '0) begin
            if (excl_i[tag_i]) tag_o = tag_inc;
            else               fin_o = 1'b1;
        end else begin
            tag_o = tag_inc;
            if (!excl_i[tag_inc]) rem_o = rem_i - TAG_W'(1);
        end
    end
endmodule

// File: rtl/alloc_tag_gen.sv
`timescale 1ns/1ps
module alloc_tag_gen
    import atg_pkg::*;
#(
    parameter int PTR_W    = 64,
    parameter int TAG_W    = 4,
    parameter int TAG_LSB  = 56,
    parameter int SEED_W   = 16,
    parameter int SEED_LSB = 8,
    parameter logic [SEED_W-1:0] TAPS = 16'h002D,
    localparam int NTAGS   = 1 << TAG_W,
    localparam int STATE_W = SEED_LSB + SEED_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_op,
    input  logic [PTR_W-1:0]   req_ptr,
    input  logic [PTR_W-1:0]   req_byte_ofs,
    input  logic [NTAGS-1:0]   req_excl,
    input  logic [TAG_W-1:0]   req_tag_ofs,
    input  logic [STATE_W-1:0] req_state,
    input  logic [NTAGS-1:0]   ctrl_excl,
    input  logic               rand_en,
    input  logic [SEED_W-1:0]  ent_value,
    input  logic               ent_fail,
    output logic               done,
    output logic [PTR_W-1:0]   res_ptr,
    output logic [STATE_W-1:0] res_state
);
    localparam int CNT_W = (TAG_W > 1) ? $clog2(TAG_W) : 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(TAG_W - 1);
    localparam logic [PTR_W-1:0] TAG_MASK =
        ((PTR_W'(1) << TAG_W) - PTR_W'(1)) << TAG_LSB;

    atg_state_e         state_q, state_d;
    atg_op_e            op_q;
    logic [PTR_W-1:0]   ptr_q;
    logic [NTAGS-1:0]   excl_q;
    logic [SEED_W-1:0]  seed_q;
    logic [TAG_W-1:0]   tag_q, rem_q;
    logic [CNT_W-1:0]   step_q;
    logic               rand_q;
    logic [STATE_W-1:0] st_q;
    logic [PTR_W-1:0]   res_ptr_q;
    logic [STATE_W-1:0] res_state_q;

    logic [SEED_W-1:0]  lfsr_seed;
    logic               lfsr_fb;
    logic [TAG_W-1:0]   walk_tag, walk_rem;
    logic               walk_fin;

    atg_lfsr_step #(.SEED_W(SEED_W), .TAPS(TAPS)) u_lfsr (
        .seed_i (seed_q),
        .seed_o (lfsr_seed),
        .fb_o   (lfsr_fb)
    );

    atg_skip_step #(.TAG_W(TAG_W)) u_skip (
        .tag_i  (tag_q),
        .rem_i  (rem_q),
        .excl_i (excl_q),
        .tag_o  (walk_tag),
        .rem_o  (walk_rem),
        .fin_o  (walk_fin)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid)
                          state_d = (atg_op_e'(req_op) == OP_GEN) ? ST_SEED : ST_WALK;
            ST_SEED:  state_d = ST_SHIFT;
            ST_SHIFT: if (step_q == LAST_STEP) state_d = ST_WALK;
            ST_WALK:  if (walk_fin) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q        <= OP_GEN;
            ptr_q       <= '0;
            excl_q      <= '0;
            seed_q      <= '0;
            tag_q       <= '0;
            rem_q       <= '0;
            step_q      <= '0;
            rand_q      <= 1'b0;
            st_q        <= '0;
            res_ptr_q   <= '0;
            res_state_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    op_q   <= atg_op_e'(req_op);
                    st_q   <= req_state;
                    seed_q <= req_state[SEED_LSB +: SEED_W];
                    rand_q <= rand_en;
                    step_q <= '0;
                    if (atg_op_e'(req_op) == OP_GEN) begin
                        ptr_q  <= req_ptr;
                        excl_q <= req_excl | ctrl_excl;
                        tag_q  <= req_state[TAG_W-1:0];
                        rem_q  <= '0;
                    end else begin
                        ptr_q  <= req_ptr + req_byte_ofs;
                        excl_q <= ctrl_excl;
                        tag_q  <= req_ptr[TAG_LSB +: TAG_W];
                        rem_q  <= req_tag_ofs;
                    end
                end
                ST_SEED: if (seed_q == '0 && rand_q)
                    seed_q <= (ent_fail || ent_value == '0) ? SEED_W'(1) : ent_value;
                ST_SHIFT: begin
                    seed_q        <= lfsr_seed;
                    rem_q[step_q] <= lfsr_fb;
                    step_q        <= step_q + CNT_W'(1);
                end
                ST_WALK: begin
                    tag_q <= walk_tag;
                    rem_q <= walk_rem;
                    if (walk_fin) begin
                        res_ptr_q <= (ptr_q & ~TAG_MASK) | (PTR_W'(walk_tag) << TAG_LSB);
                        if (op_q == OP_GEN)
                            res_state_q <= {seed_q, (SEED_LSB - TAG_W)'(0), walk_tag};
                        else
                            res_state_q <= st_q;
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        done      = (state_q == ST_DONE);
        res_ptr   = res_ptr_q;
        res_state = res_state_q;
    end
endmodule

// File: rtl/alloc_tag_gen_chk.sv
`timescale 1ns/1ps
module alloc_tag_gen_chk #(
    parameter int PTR_W    = 64,
    parameter int TAG_W    = 4,
    parameter int TAG_LSB  = 56,
    parameter int SEED_W   = 16,
    parameter int SEED_LSB = 8,
    localparam int NTAGS   = 1 << TAG_W,
    localparam int STATE_W = SEED_LSB + SEED_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               done,
    input logic [PTR_W-1:0]   res_ptr,
    input logic [STATE_W-1:0] res_state,
    input logic               op_gen,
    input logic [NTAGS-1:0]   excl_q,
    input logic [PTR_W-1:0]   ptr_q,
    input logic               rand_q
);
    localparam logic [PTR_W-1:0] TAG_MASK =
        ((PTR_W'(1) << TAG_W) - PTR_W'(1)) << TAG_LSB;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R1
    all_excl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (&excl_q)) |-> (res_ptr[TAG_LSB +: TAG_W] == '0));

    // R5
    tag_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(&excl_q)) |-> !excl_q[res_ptr[TAG_LSB +: TAG_W]]);

    // R2
    state_tag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_gen) |-> (res_state[TAG_W-1:0] == res_ptr[TAG_LSB +: TAG_W]
                              && res_state[SEED_LSB-1:TAG_W] == '0));

    // R9
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((res_ptr & ~TAG_MASK) == (ptr_q & ~TAG_MASK)));

    // R7
    seed_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_gen && rand_q) |-> (res_state[SEED_LSB +: SEED_W] != '0));
endmodule

bind alloc_tag_gen alloc_tag_gen_chk #(
    .PTR_W(PTR_W), .TAG_W(TAG_W), .TAG_LSB(TAG_LSB),
    .SEED_W(SEED_W), .SEED_LSB(SEED_LSB)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .res_ptr   (res_ptr),
    .res_state (res_state),
    .op_gen    (op_q == atg_pkg::OP_GEN),
    .excl_q    (excl_q),
    .ptr_q     (ptr_q),
    .rand_q    (rand_q)
);

// File: tb/alloc_tag_gen_test.sv
`timescale 1ns/1ps
module alloc_tag_gen_test;
    typedef struct packed {
        logic        op;
        logic [63:0] ptr;
        logic [15:0] excl;
        logic [15:0] ctrl;
        logic        ren;
        logic [15:0] ent;
        logic        efail;
        logic [3:0]  tofs;
        logic [63:0] bofs;
        logic [23:0] st;
    } vec_t;

    // stimulus table; expected results come from the model functions below
    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        // R3 R4 R6: plain generate, no exclusions
        '{1'b0, 64'h0000_1234_5678_9ABC, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 4'h0, 64'h0, 24'hACE1_05},
        // R1: both masks contribute
        '{1'b0, 64'hFF00_0000_0000_0001, 16'h00F0, 16'h0F00, 1'b0, 16'h0000, 1'b0, 4'h0, 64'h0, 24'h1234_07},
        // R6: one allowed value only
        '{1'b0, 64'h0A0B_0C0D_0E0F_1011, 16'h0000, 16'h7FFF, 1'b0, 16'h0000, 1'b0, 4'h0, 64'h0, 24'hBEEF_00},
        // R7: zero seed refilled from entropy
        '{1'b0, 64'h0000_0000_0000_0000, 16'h0000, 16'h0000, 1'b1, 16'h5A5A, 1'b0, 4'h0, 64'h0, 24'h0000_03},
        // R5 R7: zero seed kept, start excluded
        '{1'b0, 64'h7700_0000_0000_0000, 16'h0200, 16'h0000, 1'b0, 16'h9999, 1'b0, 4'h0, 64'h0, 24'h0000_09},
        // R8: add-tag with negative byte offset, req_excl ignored
        '{1'b1, 64'hF3FF_0000_0000_0100, 16'hFFFF, 16'h0024, 1'b0, 16'h0000, 1'b0, 4'h5, 64'hFFFF_FFFF_FFFF_FF00, 24'h1111_01},
        // R8 R5: add-tag with zero tag offset
        '{1'b1, 64'h0800_0000_0000_0000, 16'h0000, 16'h0100, 1'b0, 16'h0000, 1'b0, 4'h0, 64'h0000_0000_0000_0040, 24'h2222_02},
        // R8: byte add carries through the tag field
        '{1'b1, 64'h0FFF_FFFF_FFFF_FFF0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 4'h3, 64'h0000_0000_0000_0020, 24'h3333_03}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_op = 1'b0;
    logic [63:0] req_ptr = '0;
    logic [63:0] req_byte_ofs = '0;
    logic [15:0] req_excl = '0;
    logic [3:0]  req_tag_ofs = '0;
    logic [23:0] req_state = '0;
    logic [15:0] ctrl_excl = '0;
    logic        rand_en = 1'b0;
    logic [15:0] ent_value = '0;
    logic        ent_fail = 1'b0;
    logic        done;
    logic [63:0] res_ptr;
    logic [23:0] res_state;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    alloc_tag_gen uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_ptr(req_ptr), .req_byte_ofs(req_byte_ofs),
        .req_excl(req_excl), .req_tag_ofs(req_tag_ofs), .req_state(req_state),
        .ctrl_excl(ctrl_excl), .rand_en(rand_en), .ent_value(ent_value),
        .ent_fail(ent_fail), .done(done), .res_ptr(res_ptr), .res_state(res_state)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] model_steps(input logic [15:0] s);
        logic [3:0] off = '0;
        logic fb;
        for (int i = 0; i < 4; i++) begin
            fb = s[0] ^ s[2] ^ s[3] ^ s[5];
            off[i] = fb;
            s = {fb, s[15:1]};
        end
        return {s, off};
    endfunction

    function automatic logic [3:0] model_pick(input logic [3:0] t, input logic [3:0] off, input logic [15:0] ex);
        if (ex == 16'hFFFF) return 4'h0;
        if (off == 0) begin
            while (ex[t]) t = t + 4'h1;
        end else begin
            for (int k = 0; k < int'(off); k++) begin
                t = t + 4'h1;
                while (ex[t]) t = t + 4'h1;
            end
        end
        return t;
    endfunction

    task automatic model(input vec_t v, output logic [63:0] ep, output logic [23:0] es);
        logic [15:0] seed;
        logic [19:0] r;
        logic [3:0]  t;
        logic [63:0] p;
        if (!v.op) begin
            seed = v.st[23:8];
            if (seed == 0 && v.ren) seed = (v.efail || v.ent == 0) ? 16'h0001 : v.ent;
            r = model_steps(seed);
            t = model_pick(v.st[3:0], r[3:0], v.excl | v.ctrl);
            ep = v.ptr;
            ep[59:56] = t;
            es = {r[19:4], 4'h0, t};
        end else begin
            t = model_pick(v.ptr[59:56], v.tofs, v.ctrl);
            p = v.ptr + v.bofs;
            p[59:56] = t;
            ep = p;
            es = v.st;
        end
    endtask

    task automatic issue(input vec_t v, output logic [63:0] rp, output logic [23:0] rs);
        int k;
        @(negedge clk);
        req_op = v.op; req_ptr = v.ptr; req_excl = v.excl; ctrl_excl = v.ctrl;
        rand_en = v.ren; ent_value = v.ent; ent_fail = v.efail;
        req_tag_ofs = v.tofs; req_byte_ofs = v.bofs; req_state = v.st;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10 ready low while busy", 64'(req_ready), 64'h0);
        k = 0;
        while (!done && k < 600) begin
            @(negedge clk);
            k++;
        end
        chk(done == 1'b1, "R10 done seen", 64'(done), 64'h1);
        rp = res_ptr;
        rs = res_state;
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", 64'(done), 64'h0);
        chk(req_ready == 1'b1, "R10 ready after done", 64'(req_ready), 64'h1);
        chk(res_ptr == rp, "R10 result held", res_ptr, rp);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 64'h1, 64'h0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] rp, ep, rp2;
        logic [23:0] rs, es, rs2;
        vec_t v;
        repeat (3) @(negedge clk);
        // reset state, R10
        chk(req_ready == 1'b1, "R10 reset ready", 64'(req_ready), 64'h1);
        chk(done == 1'b0, "R10 reset done", 64'(done), 64'h0);
        chk(res_ptr == 64'h0, "R10 reset res_ptr", res_ptr, 64'h0);
        chk(res_state == 24'h0, "R2 reset res_state", 64'(res_state), 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i], rp, rs);
            model(VECS[i], ep, es);
            chk(rp == ep, "R1 R3 R4 R5 R6 R8 R9 vector pointer", rp, ep);
            chk(rs == es, "R2 R3 R7 vector state", 64'(rs), 64'(es));
        end

        // R7: entropy failure substitutes 1; seed 1 gives offset 1 and seed 0x1000
        v = '{1'b0, 64'h1234_0000_0000_0000, 16'h0, 16'h0, 1'b1, 16'hABCD, 1'b1, 4'h0, 64'h0, 24'h0000_00};
        issue(v, rp, rs);
        chk(rs == 24'h1000_01, "R7 entropy failure state", 64'(rs), 64'h100001);
        chk(rp == 64'h1134_0000_0000_0000, "R9 tag inserted", rp, 64'h1134_0000_0000_0000);

        // R7: zero entropy value also substitutes 1
        v.efail = 1'b0; v.ent = 16'h0000;
        issue(v, rp, rs);
        chk(rs == 24'h1000_01, "R7 zero entropy state", 64'(rs), 64'h100001);

        // R1: masks together exclude everything -> tag 0
        v = '{1'b0, 64'h0F00_0000_0000_00FF, 16'hFF00, 16'h00FF, 1'b0, 16'h0, 1'b0, 4'h0, 64'h0, 24'h4321_0A};
        issue(v, rp, rs);
        chk(rp[59:56] == 4'h0, "R1 all excluded tag", 64'(rp[59:56]), 64'h0);

        // R5: zero seed, no refill, allowed start tag -> same tag, seed stays 0
        v = '{1'b0, 64'h0000_0000_0000_0000, 16'h0, 16'h0, 1'b0, 16'h7777, 1'b0, 4'h0, 64'h0, 24'h0000_06};
        issue(v, rp, rs);
        chk(rs == 24'h0000_06, "R5 R7 zero offset keeps tag", 64'(rs), 64'h6);

        // R8: tag 3, offset 2, value 4 excluded -> 6; req_excl has no effect
        v = '{1'b1, 64'h0300_0000_0000_0010, 16'h0000, 16'h0010, 1'b0, 16'h0, 1'b0, 4'h2, 64'h0000_0000_0000_0008, 24'h5555_05};
        issue(v, rp, rs);
        chk(rp == 64'h0600_0000_0000_0018, "R8 add-tag result", rp, 64'h0600_0000_0000_0018);
        chk(rs == 24'h5555_05, "R2 add-tag state unchanged", 64'(rs), 64'h555505);
        v.excl = 16'hFFFF;
        issue(v, rp2, rs2);
        chk(rp2 == rp, "R8 req_excl ignored", rp2, rp);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule